// File: doc/BRIEF.md
# Interleaved Memory Window Router

This block sits behind one fixed host memory window. A requester hands it read or write accesses whose address is an offset into the window. The block forms the host physical address by adding the configured window base. It cuts that address into granules of 256 << g bytes and spreads consecutive granules round-robin across a configurable number of downstream host-bridge targets. Any count from one to the maximum is allowed, including counts that are not powers of two.

The routed access goes out on a downstream port with the chosen target index. The block then waits for the downstream decode stage to answer hit or miss. The two kinds of miss are answered differently. A read that finds no device returns zero data flagged as an error (poison). A write that finds no device is dropped and still completes with a clean response.

Only one request is in flight at a time. The modulo by the target count is worked out by a small sequential reducer that handles a few address bits per cycle. A combinational checker flags configurations that are not usable, so that setup software can catch them.

Top module: `mem_window_router`

## Requirements
- R1: The downstream address `dn_hpa` equals `cfg_base + req_ofs`, truncated to the host address width.
- R2: The downstream target index equals `(HPA >> (8 + cfg_gran)) mod cfg_ntgt` for any `cfg_ntgt` from 1 to 8.
- R3: Granularity code 0 selects 256-byte granules. Code g selects 256 << g bytes, for g from 0 to 6. Addresses 0x..FF and 0x..100 fall into neighbouring granules.
- R4: `cfg_err` is 1 in each of these cases, and 0 otherwise:
  - `cfg_size` is not a multiple of 2^28 bytes (256 MiB);
  - `cfg_ntgt` is 0 or greater than 8;
  - `cfg_gran` is greater than 6.
- R5: A read answered with a miss gives `rsp_err`=1 and `rsp_rdata`=0.
- R6: A write answered with a miss completes with `rsp_err`=0.
- R7: A read answered with a hit returns `dn_rdata` on `rsp_rdata` with `rsp_err`=0. A write hit completes with `rsp_err`=0.
- R8: The access length (1 to 8 bytes, at any alignment) goes downstream unchanged on `dn_len`. The same holds for the direction (`dn_write`) and the little-endian write data (`dn_wdata`).
- R9: Only one request is outstanding at a time:
  - `req_ready` is 0 from the cycle after acceptance until the response pulse;
  - while `dn_valid` is 1 and `dn_ready` is 0, the downstream address and target hold steady.
- R10: While reset is held, and right after it, `req_ready`=1, `dn_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 40 | Window base host address |
| cfg_size | input | 40 | Window size in bytes |
| cfg_ntgt | input | 4 | Number of interleave targets (1..8) |
| cfg_gran | input | 3 | Granularity code, granule = 256 << code |
| cfg_err | output | 1 | Configuration not usable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request taken on valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ofs | input | 32 | Byte offset inside the window |
| req_len | input | 4 | Access length in bytes (1..8) |
| req_wdata | input | 64 | Write data, little-endian |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream takes the request |
| dn_write | output | 1 | Downstream direction |
| dn_hpa | output | 40 | Host physical address |
| dn_tgt | output | 3 | Selected target index |
| dn_len | output | 4 | Access length |
| dn_wdata | output | 64 | Write data |
| dn_resp_valid | input | 1 | Downstream decode verdict valid |
| dn_hit | input | 1 | 1 = device found, 0 = miss |
| dn_rdata | input | 64 | Read data on hit |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Error (poison) response |
| rsp_rdata | output | 64 | Read data |

## Verification
The bench checks target counts of 3, 5, 6 and 7 against a modulo it computes itself. A reducer that only keeps the low address bits would send these accesses to the wrong target. It uses a pair of offsets that straddle a 256-byte boundary, and a design that shifted by the wrong granule would put both on the same target. It sends a read miss and a write miss and checks that the first returns zero with poison and the second completes cleanly. A design that treated both misses alike would fail one of these. It also stalls the downstream port for a cycle and checks that the routed address and target stay put, and it checks every configuration error condition on its own.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
   localparam int GRAN_BASE_LOG2  = 8;   // smallest granule is 256 bytes
   localparam int SIZE_ALIGN_LOG2 = 28;  // window size step is 256 MiB
   localparam int GRAN_ENC_W      = 3;
   localparam int MAX_GRAN_ENC    = 6;
   localparam int LEN_W           = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CALC = 2'd1,
      ST_FWD  = 2'd2,
      ST_WAIT = 2'd3
   } rtr_state_e;
endpackage

// File: rtl/mwr_cfg_check.sv
module mwr_cfg_check
   import mwr_pkg::*;
#(
   parameter int HPA_W   = 40,
   parameter int MAX_TGT = 8,
   localparam int TCNT_W = $clog2(MAX_TGT + 1)
) (
   input  logic [HPA_W-1:0]      size_i,
   input  logic [TCNT_W-1:0]     ntgt_i,
   input  logic [GRAN_ENC_W-1:0] gran_i,
   output logic                  err_o
);
   generate
      if (HPA_W <= SIZE_ALIGN_LOG2) begin : g_bad_w
         $error("HPA_W must exceed the size alignment");
      end
   endgenerate

   logic size_bad, cnt_bad, gran_bad;

   always_comb begin
      size_bad = (size_i[SIZE_ALIGN_LOG2-1:0] != '0);
      cnt_bad  = (ntgt_i == '0) || (int'(ntgt_i) > MAX_TGT);
      gran_bad = (int'(gran_i) > MAX_GRAN_ENC);
      err_o    = size_bad | cnt_bad | gran_bad;
   end
endmodule

// File: rtl/mwr_mod_reducer.sv
module mwr_mod_reducer #(
   parameter int DVD_W     = 40,
   parameter int DIV_W     = 4,
   parameter int REM_W     = 3,
   parameter int STEP_BITS = 4,
   localparam int STEPS    = (DVD_W + STEP_BITS - 1) / STEP_BITS,
   localparam int PAD_W    = STEPS * STEP_BITS,
   localparam int CNT_W    = $clog2(STEPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DIV_W-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [REM_W-1:0] remainder
);
   generate
      if (STEP_BITS < 1 || STEP_BITS > DVD_W) begin : g_bad_step
         $error("STEP_BITS out of range");
      end
      if (REM_W > DIV_W) begin : g_bad_rem
         $error("REM_W must not exceed DIV_W");
      end
   endgenerate

   logic [PAD_W-1:0] sh_q, sh_d;
   logic [DIV_W-1:0] rem_q, rem_d, div_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   // Shift STEP_BITS dividend bits into the running remainder, MSB first.
   always_comb begin
      logic [DIV_W:0] acc;
      sh_d  = sh_q;
      rem_d = rem_q;
      for (int k = 0; k < STEP_BITS; k++) begin
         acc = {rem_d, sh_d[PAD_W-1]};
         if (acc >= {1'b0, div_q}) acc = acc - {1'b0, div_q};
         rem_d = acc[DIV_W-1:0];
         sh_d  = sh_d << 1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         rem_q  <= '0;
         div_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (start) begin
         sh_q   <= PAD_W'(dividend);
         rem_q  <= '0;
         div_q  <= divisor;
         cnt_q  <= CNT_W'(STEPS);
         done_q <= 1'b0;
      end else if (cnt_q != '0) begin
         sh_q   <= sh_d;
         rem_q  <= rem_d;
         cnt_q  <= cnt_q - 1'b1;
         done_q <= (cnt_q == CNT_W'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign busy      = (cnt_q != '0);
   assign done      = done_q;
   assign remainder = rem_q[REM_W-1:0];

   AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      done && (div_q != '0) |-> rem_q < div_q); // R2
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R9
endmodule

// File: rtl/mem_window_router.sv
module mem_window_router
   import mwr_pkg::*;
#(
   parameter int HPA_W     = 40,
   parameter int OFS_W     = 32,
   parameter int DATA_W    = 64,
   parameter int MAX_TGT   = 8,
   parameter int STEP_BITS = 4,
   localparam int TCNT_W   = $clog2(MAX_TGT + 1),
   localparam int TIDX_W   = (MAX_TGT > 1) ? $clog2(MAX_TGT) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [HPA_W-1:0]      cfg_base,
   input  logic [HPA_W-1:0]      cfg_size,
   input  logic [TCNT_W-1:0]     cfg_ntgt,
   input  logic [GRAN_ENC_W-1:0] cfg_gran,
   output logic                  cfg_err,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [OFS_W-1:0]      req_ofs,
   input  logic [LEN_W-1:0]      req_len,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  dn_valid,
   input  logic                  dn_ready,
   output logic                  dn_write,
   output logic [HPA_W-1:0]      dn_hpa,
   output logic [TIDX_W-1:0]     dn_tgt,
   output logic [LEN_W-1:0]      dn_len,
   output logic [DATA_W-1:0]     dn_wdata,
   input  logic                  dn_resp_valid,
   input  logic                  dn_hit,
   input  logic [DATA_W-1:0]     dn_rdata,
   output logic                  rsp_valid,
   output logic                  rsp_err,
   output logic [DATA_W-1:0]     rsp_rdata
);
   generate
      if (OFS_W > HPA_W) begin : g_bad_ofs
         $error("OFS_W must not exceed HPA_W");
      end
      if (MAX_TGT < 1) begin : g_bad_tgt
         $error("MAX_TGT must be at least 1");
      end
      if (DATA_W < 64) begin : g_bad_data
         $error("DATA_W must hold an 8-byte access");
      end
   endgenerate

   mwr_cfg_check #(.HPA_W(HPA_W), .MAX_TGT(MAX_TGT)) u_cfg (
      .size_i (cfg_size),
      .ntgt_i (cfg_ntgt),
      .gran_i (cfg_gran),
      .err_o  (cfg_err)
   );

   rtr_state_e           st_q;
   logic [HPA_W-1:0]     hpa_q, hpa_d, granule;
   logic                 wr_q;
   logic [LEN_W-1:0]     len_q;
   logic [DATA_W-1:0]    wdata_q;
   logic [TIDX_W-1:0]    tgt_q, red_rem;
   logic                 red_done;
   logic                 accept;
   logic                 rsp_valid_q, rsp_err_q;
   logic [DATA_W-1:0]    rsp_rdata_q;

   assign accept  = (st_q == ST_IDLE) && req_valid;
   assign hpa_d   = cfg_base + HPA_W'(req_ofs);
   assign granule = hpa_d >> (GRAN_BASE_LOG2 + int'(cfg_gran));

   // Single target needs no reduction; otherwise run the sequential modulo.
   generate
      if (MAX_TGT == 1) begin : g_single
         assign red_rem  = '0;
         assign red_done = (st_q == ST_CALC);
      end else begin : g_multi
         logic red_busy;
         mwr_mod_reducer #(
            .DVD_W(HPA_W), .DIV_W(TCNT_W), .REM_W(TIDX_W), .STEP_BITS(STEP_BITS)
         ) u_mod (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (accept),
            .dividend  (granule),
            .divisor   (cfg_ntgt),
            .busy      (red_busy),
            .done      (red_done),
            .remainder (red_rem)
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         hpa_q       <= '0;
         wr_q        <= 1'b0;
         len_q       <= '0;
         wdata_q     <= '0;
         tgt_q       <= '0;
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (accept) begin
               hpa_q   <= hpa_d;
               wr_q    <= req_write;
               len_q   <= req_len;
               wdata_q <= req_wdata;
               st_q    <= ST_CALC;
            end
            ST_CALC: if (red_done) begin
               tgt_q <= red_rem;
               st_q  <= ST_FWD;
            end
            ST_FWD: if (dn_ready) st_q <= ST_WAIT;
            ST_WAIT: if (dn_resp_valid) begin
               rsp_valid_q <= 1'b1;
               rsp_err_q   <= !wr_q && !dn_hit;
               rsp_rdata_q <= (!wr_q && dn_hit) ? dn_rdata : '0;
               st_q        <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign dn_valid  = (st_q == ST_FWD);
   assign dn_write  = wr_q;
   assign dn_hpa    = hpa_q;
   assign dn_tgt    = tgt_q;
   assign dn_len    = len_q;
   assign dn_wdata  = wdata_q;
   assign rsp_valid = rsp_valid_q;
   assign rsp_err   = rsp_err_q;
   assign rsp_rdata = rsp_rdata_q;

   AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=> dn_valid && $stable(dn_hpa) && $stable(dn_tgt)); // R9
   AST_TGT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !cfg_err |-> TCNT_W'(dn_tgt) < cfg_ntgt); // R2
   AST_READ_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err |-> rsp_rdata == '0); // R5
   AST_RSP_AFTER_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(dn_resp_valid)); // R7
   AST_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      dn_resp_valid && !dn_valid && !req_ready && dn_write |=> !rsp_err); // R6
endmodule

// File: tb/mem_window_router_tb.sv
module mem_window_router_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [39:0] cfg_base, cfg_size;
   logic [3:0]  cfg_ntgt;
   logic [2:0]  cfg_gran;
   logic        cfg_err;
   logic        req_valid, req_ready, req_write;
   logic [31:0] req_ofs;
   logic [3:0]  req_len;
   logic [63:0] req_wdata;
   logic        dn_valid, dn_ready, dn_write;
   logic [39:0] dn_hpa;
   logic [2:0]  dn_tgt;
   logic [3:0]  dn_len;
   logic [63:0] dn_wdata;
   logic        dn_resp_valid, dn_hit;
   logic [63:0] dn_rdata;
   logic        rsp_valid, rsp_err;
   logic [63:0] rsp_rdata;

   mem_window_router dut_i (.*);

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   always @(posedge clk) cycles <= cycles + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [39:0] base;
      logic [31:0] ofs;
      logic [3:0]  ntgt;
      logic [2:0]  gran;
      logic        wr;
      logic        hit;
      logic [3:0]  len;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{40'h10_0000_0000, 32'h0000_0000, 4'd1, 3'd0, 1'b0, 1'b1, 4'd8},
      '{40'h10_0000_0000, 32'h0000_0300, 4'd3, 3'd0, 1'b0, 1'b1, 4'd4},
      '{40'h10_0000_0000, 32'h1234_5677, 4'd3, 3'd2, 1'b1, 1'b1, 4'd1},
      '{40'h20_1000_0000, 32'h0ABC_DEF3, 4'd5, 3'd1, 1'b0, 1'b0, 4'd2},
      '{40'h20_1000_0000, 32'hFFFF_FFF9, 4'd7, 3'd6, 1'b1, 1'b0, 4'd8},
      '{40'h00_3000_0000, 32'h0000_0801, 4'd8, 3'd3, 1'b0, 1'b1, 4'd3},
      '{40'h00_3000_0000, 32'h7000_0000, 4'd6, 3'd4, 1'b0, 1'b1, 4'd8},
      '{40'hF0_0000_0000, 32'h0001_2345, 4'd2, 3'd5, 1'b1, 1'b1, 4'd6},
      '{40'h10_0000_0000, 32'h0000_00FF, 4'd2, 3'd0, 1'b0, 1'b1, 4'd1},
      '{40'h10_0000_0000, 32'h0000_0100, 4'd2, 3'd0, 1'b0, 1'b1, 4'd1}
   };

   task automatic run_txn(input vec_t v, input int idx);
      logic [39:0] hpa;
      logic [63:0] wd, rd;
      longint unsigned tgt;
      int n;
      hpa = v.base + {8'h00, v.ofs};
      tgt = (64'(hpa) >> (8 + int'(v.gran))) % longint'(v.ntgt);
      wd  = {32'hC0DE_0000 | 32'(idx), hpa[31:0]};
      rd  = {hpa[31:0] ^ 32'hA5A5_A5A5, 32'h1000_0000 + 32'(idx)};
      cfg_base = v.base; cfg_ntgt = v.ntgt; cfg_gran = v.gran;
      @(negedge clk);
      req_valid = 1'b1; req_write = v.wr; req_ofs = v.ofs;
      req_len = v.len; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R9", "ready after accept", 64'(req_ready), 64'd0);
      n = 0;
      while (!dn_valid && n < 200) begin @(negedge clk); n++; end
      chk(dn_valid == 1'b1, "R9", "dn_valid seen", 64'(dn_valid), 64'd1);
      chk(dn_hpa == hpa, "R1", "dn_hpa", 64'(dn_hpa), 64'(hpa));
      chk(64'(dn_tgt) == tgt, (v.gran == 3'd0) ? "R3" : "R2", "dn_tgt", 64'(dn_tgt), tgt);
      chk(dn_len == v.len && dn_write == v.wr, "R8", "len/dir",
          {59'd0, dn_write, dn_len}, {59'd0, v.wr, v.len});
      if (v.wr) chk(dn_wdata == wd, "R8", "dn_wdata", dn_wdata, wd);
      @(negedge clk);
      chk(dn_valid && dn_hpa == hpa && 64'(dn_tgt) == tgt, "R9", "held while stalled",
          64'(dn_tgt), tgt);
      dn_ready = 1'b1;
      @(negedge clk);
      dn_ready = 1'b0;
      chk(dn_valid == 1'b0, "R9", "dn_valid drops", 64'(dn_valid), 64'd0);
      dn_resp_valid = 1'b1; dn_hit = v.hit; dn_rdata = rd;
      @(negedge clk);
      dn_resp_valid = 1'b0; dn_hit = 1'b0; dn_rdata = '0;
      chk(rsp_valid == 1'b1, "R7", "rsp_valid", 64'(rsp_valid), 64'd1);
      if (!v.wr && !v.hit) begin
         chk(rsp_err == 1'b1, "R5", "read miss err", 64'(rsp_err), 64'd1);
         chk(rsp_rdata == 64'd0, "R5", "read miss data", rsp_rdata, 64'd0);
      end else if (v.wr && !v.hit) begin
         chk(rsp_err == 1'b0, "R6", "write miss err", 64'(rsp_err), 64'd0);
      end else if (!v.wr) begin
         chk(rsp_err == 1'b0 && rsp_rdata == rd, "R7", "read hit data", rsp_rdata, rd);
      end else begin
         chk(rsp_err == 1'b0, "R7", "write hit err", 64'(rsp_err), 64'd0);
      end
      chk(req_ready == 1'b1, "R9", "ready after response", 64'(req_ready), 64'd1);
   endtask

   task automatic cfg_case(input logic [39:0] sz, input logic [3:0] nt,
                           input logic [2:0] g, input logic exp, input string what);
      cfg_size = sz; cfg_ntgt = nt; cfg_gran = g;
      #1;
      chk(cfg_err == exp, "R4", what, 64'(cfg_err), 64'(exp));
   endtask

   initial begin
      cfg_base = 40'h10_0000_0000; cfg_size = 40'h00_4000_0000;
      cfg_ntgt = 4'd1; cfg_gran = 3'd0;
      req_valid = 1'b0; req_write = 1'b0; req_ofs = '0; req_len = 4'd1; req_wdata = '0;
      dn_ready = 1'b0; dn_resp_valid = 1'b0; dn_hit = 1'b0; dn_rdata = '0;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && dn_valid == 1'b0 && rsp_valid == 1'b0, "R10",
          "in reset", {61'd0, req_ready, dn_valid, rsp_valid}, 64'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && dn_valid == 1'b0 && rsp_valid == 1'b0, "R10",
          "after reset", {61'd0, req_ready, dn_valid, rsp_valid}, 64'b100);

      for (int i = 0; i < NV; i++) run_txn(VEC[i], i);

      cfg_case(40'h00_1000_0000, 4'd3, 3'd6, 1'b0, "good config");
      cfg_case(40'h00_1800_0000, 4'd3, 3'd0, 1'b1, "size not 256MiB multiple");
      cfg_case(40'h00_2000_0001, 4'd3, 3'd0, 1'b1, "size odd low bit");
      cfg_case(40'h00_1000_0000, 4'd0, 3'd0, 1'b1, "zero targets");
      cfg_case(40'h00_1000_0000, 4'd9, 3'd0, 1'b1, "too many targets");
      cfg_case(40'h00_1000_0000, 4'd8, 3'd7, 1'b1, "granularity code 7");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule